// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer for a chip's main control domain. Four word-wide registers sit behind a simple synchronous write/read port: control/status, counter/command, timeout and window. Software must keep proving it is alive by writing a keyed refresh command into the counter/command register. If the count reaches the programmed timeout first, the block raises a sticky interrupt flag and issues a one-cycle reset request. A refresh that arrives too early, while the count is still under a nonzero window value, also counts as a fault and raises the reset request.

The configuration registers are guarded. A keyed unlock command opens a short writable window. One write to the control register applies the new configuration and closes the window. If that write never comes, the window closes by itself after a fixed number of counter-clock ticks. A mode bit in the control word chooses the command form. In one form each command is a single 32-bit word. In the other form each command is two consecutive 16-bit words written to the counter/command register, each carried in the low half of the data bus with the upper half zero.

The counter advances on every bus clock, or only on a single-cycle tick strobe that the surrounding chip derives from a slow low-power clock. Synchronising that tick is done outside this block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, control/status (address 0) reads 0x0000_2020: the command-width bit 13 and the update-permit bit 5 are set. Address 1 reads count 0, address 2 reads timeout 1000, address 3 reads window 0, and both `rst_req` and `irq` are low.
- R2: With bit 13 set, a single write of 0xD928C520 to address 1 sets the unlocked bit 11 and clears the applied bit 10. Both changes are visible on the cycle after the write.
- R3: With bit 13 clear, unlock needs the write 0x0000C520 followed by the next address-1 write of 0x0000D928. The first word alone does not set bit 11, and the 32-bit unlock word has no effect in this mode.
- R4: Writes to the timeout (address 2) and window (address 3) registers are ignored while bit 11 is clear.
- R5: If no control write follows an unlock, bit 11 clears after exactly 128 counter-clock ticks.
- R6: A control write while unlocked does several things at once. It loads enable (bit 7), update-permit (bit 5), clock select (bits 9:8) and command width (bit 13). It clears bit 11, sets bit 10 and restarts the count at 0.
- R7: With bit 13 set, a write of 0xB480A602 to address 1 restarts the count at 0 on the next cycle.
- R8: With bit 13 clear, a refresh needs 0x0000A602 followed by the next address-1 write of 0x0000B480. If the second write is any other value, the sequence is dropped and the count keeps running. The 32-bit refresh word has no effect in this mode.
- R9: While enabled, a counter tick that finds the count equal to the timeout value does three things. It sets flag bit 14, drives `irq`, and drives `rst_req` high for exactly one cycle. The count then restarts at 0.
- R10: Writing 1 to bit 14 of address 0 clears the flag, even while locked. That write leaves the other control bits unchanged.
- R11: With a nonzero window value, a refresh while the count is below the window value raises `rst_req` on the next cycle. A refresh at or above the window value does not raise it.
- R12: Clock select code 0 advances the count on every clock. Any nonzero code advances it only in cycles where `lp_tick` is high.
- R13: Once a control write has cleared bit 5, later unlock commands are refused. Bit 11 stays 0 and the configuration registers remain locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_tick | input | 1 | One-cycle strobe from the low-power time base, already synchronised |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 counter/command, 2 timeout, 3 window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from register state |
| irq | output | 1 | Timeout interrupt (flag bit 14) |
| rst_req | output | 1 | Reset request pulse, registered |

## Verification
Every register write takes effect at the clock edge that samples it. Unlock, relock, applied, flag and count changes can therefore be read back one cycle after the write. The bench drives on the falling edge and reads between edges, so each read lands in that following cycle. Expiry and early-refresh faults register `rst_req` on the edge that detects them. With bus-clock counting, the pulse appears T+1 edges after a refresh for a timeout of T. The bench counts edges from the refresh and checks the low state one cycle before the pulse, the pulse itself, and its removal one cycle later. The 128-tick relock window is checked the same way: bit 11 must still be high after 127 edges and low after the 128th.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    REG_CS    = 2'd0,
    REG_CMD   = 2'd1,
    REG_TOVAL = 2'd2,
    REG_WIN   = 2'd3
  } reg_sel_e;

  // control/status bit positions (software decodes these)
  localparam int unsigned CS_UPD   = 5;
  localparam int unsigned CS_EN    = 7;
  localparam int unsigned CS_SEL   = 8;
  localparam int unsigned CS_DONE  = 10;
  localparam int unsigned CS_UNLK  = 11;
  localparam int unsigned CS_CMD32 = 13;
  localparam int unsigned CS_FLAG  = 14;

  localparam logic [31:0] KEY_OPEN_W32 = 32'hD928_C520;
  localparam logic [31:0] KEY_FEED_W32 = 32'hB480_A602;
  localparam logic [15:0] KEY_OPEN_LO  = 16'hC520;
  localparam logic [15:0] KEY_OPEN_HI  = 16'hD928;
  localparam logic [15:0] KEY_FEED_LO  = 16'hA602;
  localparam logic [15:0] KEY_FEED_HI  = 16'hB480;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_OPEN_HALF = 2'd1,
    SEQ_FEED_HALF = 2'd2
  } seq_e;

  // a 16-bit command half travels in the low half of the bus, upper half zero
  function automatic logic half_key(input logic [31:0] w, input logic [15:0] k);
    return w == {16'h0000, k};
  endfunction

  // refresh arriving under a nonzero window is early
  function automatic logic early_feed(input logic [31:0] cnt, input logic [31:0] win);
    return (win != 32'd0) && (cnt < win);
  endfunction

  function automatic logic [31:0] count_step(input logic [31:0] cnt);
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/kwdt_cmd_decode.sv
module kwdt_cmd_decode
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] wdata,
  input  logic        wide_mode,
  output logic        open_evt,
  output logic        feed_evt
);

  seq_e seq_q, seq_d;

  always_comb begin
    seq_d    = seq_q;
    open_evt = 1'b0;
    feed_evt = 1'b0;
    if (wide_mode) begin
      seq_d = SEQ_IDLE;
      if (cmd_wr) begin
        open_evt = (wdata == KEY_OPEN_W32);
        feed_evt = (wdata == KEY_FEED_W32);
      end
    end else if (cmd_wr) begin
      unique case (seq_q)
        SEQ_OPEN_HALF: begin
          open_evt = half_key(wdata, KEY_OPEN_HI);
          seq_d    = SEQ_IDLE;
        end
        SEQ_FEED_HALF: begin
          feed_evt = half_key(wdata, KEY_FEED_HI);
          seq_d    = SEQ_IDLE;
        end
        default: begin
          if (half_key(wdata, KEY_OPEN_LO))      seq_d = SEQ_OPEN_HALF;
          else if (half_key(wdata, KEY_FEED_LO)) seq_d = SEQ_FEED_HALF;
          else                                   seq_d = SEQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= SEQ_IDLE;
    else        seq_q <= seq_d;
  end

  // R8
  bad_half_drops_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wide_mode && !half_key(wdata, KEY_OPEN_LO) && !half_key(wdata, KEY_FEED_LO))
      |=> (seq_q == SEQ_IDLE));

  // R2
  wide_mode_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |=> (seq_q == SEQ_IDLE));

endmodule

// File: rtl/kwdt_unlock_ctl.sv
module kwdt_unlock_ctl #(
  parameter int unsigned OPEN_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic open_req,
  input  logic upd_ok,
  input  logic cfg_apply,
  output logic unlocked
);

  localparam int unsigned WW = (OPEN_TICKS > 1) ? $clog2(OPEN_TICKS) : 1;
  localparam logic [WW-1:0] LAST = WW'(OPEN_TICKS - 1);

  logic [WW-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      wcnt_q   <= '0;
    end else if (cfg_apply) begin
      unlocked <= 1'b0;
      wcnt_q   <= '0;
    end else if (open_req && upd_ok) begin
      unlocked <= 1'b1;
      wcnt_q   <= '0;
    end else if (unlocked && tick) begin
      if (wcnt_q == LAST) begin
        unlocked <= 1'b0;
        wcnt_q   <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(open_req && upd_ok));

  // R13
  refused_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_req && !upd_ok && !unlocked) |=> !unlocked);

  // R5
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !tick && !cfg_apply) |=> unlocked);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          feed,
  input  logic          restart,
  input  logic [CW-1:0] timeout,
  input  logic [CW-1:0] window,
  output logic [CW-1:0] count,
  output logic          expire_evt,
  output logic          early_evt
);

  logic step;

  assign step       = run && tick;
  assign expire_evt = step && (count == timeout);
  assign early_evt  = feed && run && early_feed(32'(count), 32'(window));

  always_ff @(posedge clk) begin
    if (!rst_n)                           count <= '0;
    else if (feed || restart || expire_evt) count <= '0;
    else if (step)                        count <= CW'(count_step(32'(count)));
  end

  // R7
  feed_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (count == '0));

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !feed && !restart) |=> $stable(count));

  // R9
  expire_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (count == '0));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned OPEN_TICKS = 128,
  parameter int unsigned TOUT_RST   = 1000,
  parameter bit          WIDE_RST   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        rst_req
);

  logic          en_q, upd_q, wide_q, flag_q, done_q, rst_req_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] tout_q, win_q, count;

  logic cs_wr, cmd_wr, tout_wr, win_wr;
  logic unlocked, cfg_apply, tick;
  logic open_evt, feed_evt, expire_evt, early_evt;

  assign cs_wr   = reg_wr && (reg_addr == REG_CS);
  assign cmd_wr  = reg_wr && (reg_addr == REG_CMD);
  assign tout_wr = reg_wr && (reg_addr == REG_TOVAL);
  assign win_wr  = reg_wr && (reg_addr == REG_WIN);

  assign cfg_apply = cs_wr && unlocked;
  assign tick      = (sel_q == 2'd0) ? 1'b1 : lp_tick;

  kwdt_cmd_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .wdata     (reg_wdata),
    .wide_mode (wide_q),
    .open_evt  (open_evt),
    .feed_evt  (feed_evt)
  );

  kwdt_unlock_ctl #(.OPEN_TICKS(OPEN_TICKS)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .open_req  (open_evt),
    .upd_ok    (upd_q),
    .cfg_apply (cfg_apply),
    .unlocked  (unlocked)
  );

  kwdt_counter #(.CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (en_q),
    .feed       (feed_evt),
    .restart    (cfg_apply),
    .timeout    (tout_q),
    .window     (win_q),
    .count      (count),
    .expire_evt (expire_evt),
    .early_evt  (early_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b1;
      sel_q  <= 2'd0;
      wide_q <= WIDE_RST;
      done_q <= 1'b0;
    end else if (cfg_apply) begin
      en_q   <= reg_wdata[CS_EN];
      upd_q  <= reg_wdata[CS_UPD];
      sel_q  <= reg_wdata[CS_SEL +: 2];
      wide_q <= reg_wdata[CS_CMD32];
      done_q <= 1'b1;
    end else if (open_evt && upd_q) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tout_q <= CW'(TOUT_RST);
      win_q  <= '0;
    end else begin
      if (tout_wr && unlocked) tout_q <= reg_wdata[CW-1:0];
      if (win_wr && unlocked)  win_q  <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (expire_evt)                        flag_q <= 1'b1;
      else if (cs_wr && reg_wdata[CS_FLAG]) flag_q <= 1'b0;
      rst_req_q <= expire_evt || early_evt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      REG_CS: begin
        reg_rdata[CS_UPD]      = upd_q;
        reg_rdata[CS_EN]       = en_q;
        reg_rdata[CS_SEL +: 2] = sel_q;
        reg_rdata[CS_DONE]     = done_q;
        reg_rdata[CS_UNLK]     = unlocked;
        reg_rdata[CS_CMD32]    = wide_q;
        reg_rdata[CS_FLAG]     = flag_q;
      end
      REG_CMD:   reg_rdata = 32'(count);
      REG_TOVAL: reg_rdata = 32'(tout_q);
      default:   reg_rdata = 32'(win_q);
    endcase
  end

  assign irq     = flag_q;
  assign rst_req = rst_req_q;

  // R9
  expire_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (rst_req && irq));

  // R4
  locked_tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_wr && !unlocked) |=> $stable(tout_q));

  // R6
  apply_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> (done_q && !unlocked));

  // R10
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_wr && reg_wdata[CS_FLAG] && !expire_evt) |=> !irq);

  // R11
  early_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> rst_req);

endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  keyed_wdt i_keyed_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_tick   (lp_tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .rst_req   (rst_req)
  );

  localparam logic [31:0] OPEN32 = 32'hD928_C520;
  localparam logic [31:0] FEED32 = 32'hB480_A602;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic open16();
    wr(2'd1, 32'h0000_C520);
    wr(2'd1, 32'h0000_D928);
  endtask

  task automatic t_reset();
    chk_reg("R1 cs", 2'd0, 32'h0000_2020);
    chk_reg("R1 count", 2'd1, 32'd0);
    chk_reg("R1 timeout", 2'd2, 32'd1000);
    chk_reg("R1 window", 2'd3, 32'd0);
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_locked();
    wr(2'd2, 32'd20);
    chk_reg("R4 timeout locked", 2'd2, 32'd1000);
    wr(2'd3, 32'd5);
    chk_reg("R4 window locked", 2'd3, 32'd0);
  endtask

  task automatic t_open32();
    wr(2'd1, OPEN32);
    chk_reg("R2 unlocked", 2'd0, 32'h0000_2820);
    wr(2'd2, 32'd20);
    chk_reg("R2 timeout writable", 2'd2, 32'd20);
    wr(2'd0, 32'h0000_60A0);
    chk_reg("R6 cs applied", 2'd0, 32'h0000_24A0);
    chk_reg("R6 count restart", 2'd1, 32'd0);
  endtask

  task automatic t_expire();
    step(5);
    chk_reg("R12 count per clock", 2'd1, 32'd5);
    wr(2'd1, FEED32);
    chk_reg("R7 refresh", 2'd1, 32'd0);
    step(20);
    chk_reg("R9 count at timeout", 2'd1, 32'd20);
    check("R9 no early pulse", {31'd0, rst_req}, 32'd0);
    step(1);
    check("R9 rst_req pulse", {31'd0, rst_req}, 32'd1);
    check("R9 irq", {31'd0, irq}, 32'd1);
    chk_reg("R9 wrap", 2'd1, 32'd0);
    chk_reg("R9 flag bit", 2'd0, 32'h0000_64A0);
    step(1);
    check("R9 one cycle", {31'd0, rst_req}, 32'd0);
    wr(2'd0, 32'h0000_4000);
    chk_reg("R10 flag cleared", 2'd0, 32'h0000_24A0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_window();
    wr(2'd1, OPEN32);
    wr(2'd3, 32'd10);
    wr(2'd0, 32'h0000_20A0);
    step(3);
    wr(2'd1, FEED32);
    check("R11 early refresh", {31'd0, rst_req}, 32'd1);
    step(14);
    check("R11 quiet", {31'd0, rst_req}, 32'd0);
    chk_reg("R11 count", 2'd1, 32'd14);
    wr(2'd1, FEED32);
    check("R11 late refresh ok", {31'd0, rst_req}, 32'd0);
    chk_reg("R11 late refresh count", 2'd1, 32'd0);
  endtask

  task automatic t_mode16();
    wr(2'd1, OPEN32);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd1000);
    wr(2'd0, 32'h0000_00A0);
    chk_reg("R6 narrow mode", 2'd0, 32'h0000_04A0);
    step(4);
    wr(2'd1, FEED32);
    chk_reg("R8 wide word ignored", 2'd1, 32'd5);
    wr(2'd1, 32'h0000_A602);
    wr(2'd1, 32'h0000_B480);
    chk_reg("R8 pair refresh", 2'd1, 32'd0);
    step(3);
    wr(2'd1, 32'h0000_A602);
    wr(2'd1, 32'h0000_1234);
    chk_reg("R8 aborted", 2'd1, 32'd5);
    wr(2'd1, 32'h0000_B480);
    chk_reg("R8 lone second half", 2'd1, 32'd6);
    wr(2'd1, OPEN32);
    chk_reg("R3 wide unlock ignored", 2'd0, 32'h0000_04A0);
    wr(2'd1, 32'h0000_C520);
    chk_reg("R3 first half only", 2'd0, 32'h0000_04A0);
    wr(2'd1, 32'h0000_D928);
    chk_reg("R3 pair unlock", 2'd0, 32'h0000_08A0);
    step(127);
    chk_reg("R5 still open", 2'd0, 32'h0000_08A0);
    step(1);
    chk_reg("R5 relocked", 2'd0, 32'h0000_00A0);
    wr(2'd2, 32'd55);
    chk_reg("R4 after relock", 2'd2, 32'd1000);
  endtask

  task automatic t_clksel();
    open16();
    wr(2'd0, 32'h0000_01A0);
    chk_reg("R12 slow select", 2'd0, 32'h0000_05A0);
    step(10);
    chk_reg("R12 no tick hold", 2'd1, 32'd0);
    lp_tick = 1'b1;
    step(3);
    lp_tick = 1'b0;
    chk_reg("R12 three ticks", 2'd1, 32'd3);
    step(5);
    chk_reg("R12 hold again", 2'd1, 32'd3);
  endtask

  task automatic t_updlock();
    open16();
    wr(2'd0, 32'h0000_0080);
    chk_reg("R13 upd cleared", 2'd0, 32'h0000_0480);
    open16();
    chk_reg("R13 unlock refused", 2'd0, 32'h0000_0480);
    wr(2'd2, 32'd7);
    chk_reg("R13 timeout locked", 2'd2, 32'd1000);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_locked();
    t_open32();
    t_expire();
    t_window();
    t_mode16();
    t_clksel();
    t_updlock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule